// File: doc/BRIEF.md
# Backtracking Probe Path-Setup Switch

This block is one circuit-switched crossbar switch, meant for any stage of a three-stage Clos fabric. It has no packet queues. A connection is set up by a probe. An upstream neighbour raises a request on one input and presents a header that holds a destination switch number and a destination port. A controller for that input latches the header. It then works out which outputs are worth trying. When the destination switch is this switch, only the named port is worth trying. Otherwise any output will do, because any middle path can reach the target. The controller then asks a per-output round-robin arbiter for one of those outputs that is free and whose downstream link is reported free.

A granted output raises a registered request toward the downstream switch and carries the header with it. The downstream answer decides what happens next:
- An accept completes the circuit. After that, data crosses the crossbar unchanged until the upstream neighbour drops its request.
- A reject marks that output as tried, and the controller moves on to the next untried candidate.
- When every candidate has been tried and rejected, the input answers nACK.
- When untried candidates remain but none of them is free, the input backtracks at once and hands the header back upstream, so that the upstream switch can try another route.

The input controllers update on the rising clock edge. The arbiter updates on the falling edge, so a new probe holds a grant, or has been turned back, one cycle after it arrives.

Top module: `probe_path_switch`

## Requirements
- R1: While reset is low, every status output (upAck, upNack, upBack), every dnReq, every dnHdr and every dnData lane is zero.
- R2: A header is {destination switch in the upper SW_W bits, destination port in the lower bits}. When the destination switch equals localAddr, only the output numbered by the destination port is a candidate. Otherwise every output is a candidate and the lowest-numbered free one is probed first. The probed output shows dnReq=1 and dnHdr equal to the header two rising edges after upReq is first sampled high.
- R3: When no untried candidate is free one cycle after the probe arrives, upBack rises on that edge for exactly one cycle, with upBackHdr equal to the stored header.
- R4: dnAck on the output that the input is probing moves the input to the connected state: upAck is high from the next edge, and dnReq on that output drops one edge later.
- R5: One edge after upAck rises, dnData of the connected output equals upData of its input. Outputs with no connection drive zero.
- R6: dnNack on the probed output excludes that output for the rest of this probe. The next lowest free untried candidate is probed, and its dnReq appears two edges after the reject is sampled.
- R7: When every candidate has been rejected, upNack is high for exactly one cycle and the output is released (dnReq low).
- R8: Inputs that compete for one output are served in round-robin order. The next search starts one past the last winner. A loser with no other free candidate backtracks.
- R9: An output whose dnLinkFree is low is never granted to a new probe.
- R10: Dropping upReq while connected clears upAck on the next edge. The output data lane returns to zero one edge after that.
- R11: At most one of upAck, upNack and upBack is high for an input, and an input never holds more than one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Probe clock: controllers on the rising edge, arbiter on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| localAddr | input | SW_W | Number of this switch |
| upReq | input | NUM_PORTS | Per-input request from upstream, held for the whole connection |
| upHdr | input | NUM_PORTS*HDR_W | Per-input probe header {dest switch, dest port} |
| upData | input | NUM_PORTS*DATA_W | Per-input payload |
| upAck | output | NUM_PORTS | Circuit established |
| upNack | output | NUM_PORTS | All candidates rejected (one-cycle pulse) |
| upBack | output | NUM_PORTS | Probe turned back upstream (one-cycle pulse) |
| upBackHdr | output | NUM_PORTS*HDR_W | Header returned with a backtrack, zero otherwise |
| dnLinkFree | input | NUM_PORTS | Downstream link of each output is free |
| dnReq | output | NUM_PORTS | Registered probe request toward downstream |
| dnHdr | output | NUM_PORTS*HDR_W | Registered header forwarded downstream |
| dnAck | input | NUM_PORTS | Downstream accepts the probe on this output |
| dnNack | input | NUM_PORTS | Downstream rejects the probe on this output |
| dnData | output | NUM_PORTS*DATA_W | Crossbar output lanes |

## Verification
The assertions assume the following about the neighbours of this block:
- An upstream neighbour keeps upReq high until it has seen upAck, upNack or upBack.
- A downstream neighbour answers with dnAck or dnNack only on an output whose dnReq it currently sees, and never with both at once.

Under those assumptions, a rising upAck always follows an accept, and a falling upAck always follows a dropped request. The stimulus keeps to these rules. Every answer is a single-cycle pulse on the output that is probing, and requests are withdrawn only after a status has been observed. dnLinkFree changes only while no probe is in flight.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_BACK,
    ST_ACK,
    ST_NACK
  } probeState_e;

  // strobes from the control half to the datapath half, one per output
  typedef struct packed {
    logic probeOn;  // output locked by an input that is still probing
    logic pathOn;   // output locked by an input whose circuit is up
  } portStrobe_t;

endpackage

// File: rtl/pps_control.sv
module pps_control
  import pps_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int SW_W      = 2,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int HDR_W     = SW_W + PORT_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SW_W-1:0]             localAddr,
  input  logic [NUM_PORTS-1:0]        upReq,
  input  logic [NUM_PORTS*HDR_W-1:0]  upHdr,
  input  logic [NUM_PORTS-1:0]        dnLinkFree,
  input  logic [NUM_PORTS-1:0]        dnAck,
  input  logic [NUM_PORTS-1:0]        dnNack,
  output logic [NUM_PORTS-1:0]        upAck,
  output logic [NUM_PORTS-1:0]        upNack,
  output logic [NUM_PORTS-1:0]        upBack,
  output logic [NUM_PORTS*HDR_W-1:0]  upBackHdr,
  output portStrobe_t [NUM_PORTS-1:0] strobe,
  output logic [NUM_PORTS*PORT_W-1:0] selFlat,
  output logic [NUM_PORTS*HDR_W-1:0]  hdrFlat
);

  probeState_e          state_q  [NUM_PORTS];
  logic [HDR_W-1:0]     hdr_q    [NUM_PORTS];
  logic [NUM_PORTS-1:0] tried_q  [NUM_PORTS];
  logic [NUM_PORTS-1:0] locked_q;
  logic [PORT_W-1:0]    owner_q  [NUM_PORTS];
  logic [PORT_W-1:0]    rrPtr_q  [NUM_PORTS];

  logic [NUM_PORTS-1:0] profit    [NUM_PORTS];
  logic [NUM_PORTS-1:0] cand      [NUM_PORTS];
  logic [NUM_PORTS-1:0] grantMine [NUM_PORTS];
  logic [NUM_PORTS-1:0] want      [NUM_PORTS];
  logic [NUM_PORTS-1:0] avail;
  logic [NUM_PORTS-1:0] winOk;
  logic [PORT_W-1:0]    winIdx    [NUM_PORTS];

  function automatic logic [NUM_PORTS-1:0] lowestOne(input logic [NUM_PORTS-1:0] v);
    lowestOne = '0;
    for (int b = NUM_PORTS - 1; b >= 0; b--) begin
      if (v[b]) begin
        lowestOne    = '0;
        lowestOne[b] = 1'b1;
      end
    end
  endfunction

  // candidate building and per-input request
  always_comb begin
    avail = ~locked_q & dnLinkFree;
    for (int i = 0; i < NUM_PORTS; i++) begin
      profit[i] = '1;
      if (hdr_q[i][HDR_W-1:PORT_W] == localAddr) begin
        profit[i] = '0;
        profit[i][hdr_q[i][PORT_W-1:0]] = 1'b1;
      end
      cand[i]      = profit[i] & ~tried_q[i];
      grantMine[i] = '0;
      for (int o = 0; o < NUM_PORTS; o++)
        grantMine[i][o] = locked_q[o] && (owner_q[o] == PORT_W'(i));
      case (state_q[i])
        ST_PROBE: want[i] = (|(grantMine[i] & cand[i])) ? (grantMine[i] & cand[i])
                                                         : lowestOne(cand[i] & avail);
        ST_ACK:   want[i] = grantMine[i];
        default:  want[i] = '0;
      endcase
    end
  end

  // round-robin pick per output, search starts at the pointer
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      winOk[o]  = 1'b0;
      winIdx[o] = '0;
      for (int k = NUM_PORTS - 1; k >= 0; k--) begin
        if (want[(int'(rrPtr_q[o]) + k) % NUM_PORTS][o]) begin
          winOk[o]  = 1'b1;
          winIdx[o] = PORT_W'((int'(rrPtr_q[o]) + k) % NUM_PORTS);
        end
      end
    end
  end

  // input controllers: rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        state_q[i] <= ST_IDLE;
        hdr_q[i]   <= '0;
        tried_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        case (state_q[i])
          ST_IDLE: begin
            tried_q[i] <= '0;
            if (upReq[i]) begin
              state_q[i] <= ST_PROBE;
              hdr_q[i]   <= upHdr[i*HDR_W +: HDR_W];
            end
          end
          ST_PROBE: begin
            if (|(grantMine[i] & cand[i])) begin
              if (|(dnAck & grantMine[i] & cand[i]))
                state_q[i] <= ST_ACK;
              else if (|(dnNack & grantMine[i] & cand[i]))
                tried_q[i] <= tried_q[i] | grantMine[i];
            end else if (cand[i] == '0) begin
              state_q[i] <= ST_NACK;
            end else if ((cand[i] & avail) == '0) begin
              state_q[i] <= ST_BACK;
            end
          end
          ST_ACK:  if (!upReq[i]) state_q[i] <= ST_IDLE;
          default: state_q[i] <= ST_IDLE;
        endcase
      end
    end
  end

  // output arbiter: falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      locked_q <= '0;
      for (int o = 0; o < NUM_PORTS; o++) begin
        owner_q[o] <= '0;
        rrPtr_q[o] <= '0;
      end
    end else begin
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (locked_q[o]) begin
          if (!want[owner_q[o]][o]) locked_q[o] <= 1'b0;
        end else if (dnLinkFree[o] && winOk[o]) begin
          locked_q[o] <= 1'b1;
          owner_q[o]  <= winIdx[o];
          rrPtr_q[o]  <= PORT_W'((int'(winIdx[o]) + 1) % NUM_PORTS);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      upAck[i]  = (state_q[i] == ST_ACK);
      upNack[i] = (state_q[i] == ST_NACK);
      upBack[i] = (state_q[i] == ST_BACK);
      upBackHdr[i*HDR_W +: HDR_W] = (state_q[i] == ST_BACK) ? hdr_q[i] : '0;
      hdrFlat[i*HDR_W +: HDR_W]   = hdr_q[i];
    end
    for (int o = 0; o < NUM_PORTS; o++) begin
      strobe[o].probeOn = locked_q[o] && (state_q[owner_q[o]] == ST_PROBE);
      strobe[o].pathOn  = locked_q[o] && (state_q[owner_q[o]] == ST_ACK);
      selFlat[o*PORT_W +: PORT_W] = owner_q[o];
    end
  end

endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int SW_W      = 2,
  parameter  int DATA_W    = 8,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int HDR_W     = SW_W + PORT_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  portStrobe_t [NUM_PORTS-1:0] strobe,
  input  logic [NUM_PORTS*PORT_W-1:0] selFlat,
  input  logic [NUM_PORTS*HDR_W-1:0]  hdrFlat,
  input  logic [NUM_PORTS*DATA_W-1:0] upData,
  output logic [NUM_PORTS-1:0]        dnReq,
  output logic [NUM_PORTS*HDR_W-1:0]  dnHdr,
  output logic [NUM_PORTS*DATA_W-1:0] dnData
);

  logic [NUM_PORTS-1:0] pathQ;
  logic [PORT_W-1:0]    selQ     [NUM_PORTS];
  logic [HDR_W-1:0]     ownerHdr [NUM_PORTS];

  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++)
      ownerHdr[o] = hdrFlat[int'(selFlat[o*PORT_W +: PORT_W])*HDR_W +: HDR_W];
  end

  // output controllers: retiming stage toward downstream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dnReq <= '0;
      dnHdr <= '0;
      pathQ <= '0;
      for (int o = 0; o < NUM_PORTS; o++) selQ[o] <= '0;
    end else begin
      for (int o = 0; o < NUM_PORTS; o++) begin
        dnReq[o] <= strobe[o].probeOn;
        pathQ[o] <= strobe[o].pathOn;
        selQ[o]  <= selFlat[o*PORT_W +: PORT_W];
        dnHdr[o*HDR_W +: HDR_W] <= strobe[o].probeOn ? ownerHdr[o] : '0;
      end
    end
  end

  // crossbar: one multiplexer per output
  generate
    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_mux
      assign dnData[o*DATA_W +: DATA_W] =
        pathQ[o] ? upData[int'(selQ[o])*DATA_W +: DATA_W] : '0;
    end
  endgenerate

endmodule

// File: rtl/probe_path_switch.sv
module probe_path_switch
  import pps_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int SW_W      = 2,
  parameter  int DATA_W    = 8,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int HDR_W     = SW_W + PORT_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SW_W-1:0]             localAddr,
  input  logic [NUM_PORTS-1:0]        upReq,
  input  logic [NUM_PORTS*HDR_W-1:0]  upHdr,
  input  logic [NUM_PORTS*DATA_W-1:0] upData,
  output logic [NUM_PORTS-1:0]        upAck,
  output logic [NUM_PORTS-1:0]        upNack,
  output logic [NUM_PORTS-1:0]        upBack,
  output logic [NUM_PORTS*HDR_W-1:0]  upBackHdr,
  input  logic [NUM_PORTS-1:0]        dnLinkFree,
  output logic [NUM_PORTS-1:0]        dnReq,
  output logic [NUM_PORTS*HDR_W-1:0]  dnHdr,
  input  logic [NUM_PORTS-1:0]        dnAck,
  input  logic [NUM_PORTS-1:0]        dnNack,
  output logic [NUM_PORTS*DATA_W-1:0] dnData
);

  portStrobe_t [NUM_PORTS-1:0] strobe;
  logic [NUM_PORTS*PORT_W-1:0] selFlat;
  logic [NUM_PORTS*HDR_W-1:0]  hdrFlat;

  pps_control #(.NUM_PORTS(NUM_PORTS), .SW_W(SW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .localAddr(localAddr), .upReq(upReq), .upHdr(upHdr),
    .dnLinkFree(dnLinkFree), .dnAck(dnAck), .dnNack(dnNack),
    .upAck(upAck), .upNack(upNack), .upBack(upBack), .upBackHdr(upBackHdr),
    .strobe(strobe), .selFlat(selFlat), .hdrFlat(hdrFlat)
  );

  pps_datapath #(.NUM_PORTS(NUM_PORTS), .SW_W(SW_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selFlat(selFlat), .hdrFlat(hdrFlat),
    .upData(upData), .dnReq(dnReq), .dnHdr(dnHdr), .dnData(dnData)
  );

endmodule

// File: rtl/pps_checker.sv
module pps_checker
  import pps_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        upReq,
  input logic [NUM_PORTS-1:0]        upAck,
  input logic [NUM_PORTS-1:0]        upNack,
  input logic [NUM_PORTS-1:0]        upBack,
  input logic [NUM_PORTS-1:0]        dnAck,
  input portStrobe_t [NUM_PORTS-1:0] strobe,
  input logic [NUM_PORTS*PORT_W-1:0] selFlat
);

  int holdCnt [NUM_PORTS];

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      holdCnt[i] = 0;
      for (int o = 0; o < NUM_PORTS; o++)
        if ((strobe[o].probeOn || strobe[o].pathOn) &&
            selFlat[o*PORT_W +: PORT_W] == PORT_W'(i))
          holdCnt[i] = holdCnt[i] + 1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
      p_back_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
        upBack[i] |=> !upBack[i]);
      p_ack_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
        $rose(upAck[i]) |-> $past(|dnAck));
      p_nack_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
        upNack[i] |=> !upNack[i]);
      p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
        $fell(upAck[i]) |-> $past(!upReq[i]));
      p_status_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0({upAck[i], upNack[i], upBack[i]}));
      p_single_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
        holdCnt[i] <= 1);
    end
  endgenerate

endmodule

bind probe_path_switch pps_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rstN(rstN), .upReq(upReq), .upAck(upAck), .upNack(upNack),
  .upBack(upBack), .dnAck(dnAck), .strobe(strobe), .selFlat(selFlat)
);

// File: tb/sim_probe_path_switch.sv
module sim_probe_path_switch;
  localparam int N  = 4;
  localparam int SW = 2;
  localparam int DW = 8;
  localparam int HW = 4;

  localparam int K_ACK = 0, K_NACK = 1, K_BACK = 2, K_DNREQ = 3,
                 K_DNHDR = 4, K_DATA = 5, K_BHDR = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [SW-1:0]   localAddr = 2'd1;
  logic [N-1:0]    upReq = '0, dnLinkFree = '1, dnAck = '0, dnNack = '0;
  logic [N*HW-1:0] upHdr = '0;
  logic [N*DW-1:0] upData = '0;
  logic [N-1:0]    upAck, upNack, upBack, dnReq;
  logic [N*HW-1:0] upBackHdr, dnHdr;
  logic [N*DW-1:0] dnData;

  probe_path_switch #(.NUM_PORTS(N), .SW_W(SW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .localAddr(localAddr), .upReq(upReq), .upHdr(upHdr),
    .upData(upData), .upAck(upAck), .upNack(upNack), .upBack(upBack),
    .upBackHdr(upBackHdr), .dnLinkFree(dnLinkFree), .dnReq(dnReq), .dnHdr(dnHdr),
    .dnAck(dnAck), .dnNack(dnNack), .dnData(dnData)
  );

  typedef struct {
    int    cyc;
    int    kind;
    int    idx;
    int    val;
    string tag;
  } expItem_t;

  expItem_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(int kind, int idx);
    case (kind)
      K_ACK:   return int'(upAck[idx]);
      K_NACK:  return int'(upNack[idx]);
      K_BACK:  return int'(upBack[idx]);
      K_DNREQ: return int'(dnReq[idx]);
      K_DNHDR: return int'(dnHdr[idx*HW +: HW]);
      K_DATA:  return int'(dnData[idx*DW +: DW]);
      default: return int'(upBackHdr[idx*HW +: HW]);
    endcase
  endfunction

  task automatic checkVal(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // driver side: queue an expected value dly rising edges ahead
  task automatic expectAt(int dly, int kind, int idx, int val, string tag);
    sbq.push_back('{cyc + dly, kind, idx, val, tag});
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic setHdr(int i, int sw, int port);
    upHdr[i*HW +: HW] = {SW'(sw), 2'(port)};
  endtask

  // monitor: pop and compare items that fall due on this edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      for (int q = sbq.size() - 1; q >= 0; q--) begin
        if (sbq[q].cyc == cyc) begin
          checkVal(sbq[q].tag, $sformatf("kind%0d idx%0d", sbq[q].kind, sbq[q].idx),
                   observe(sbq[q].kind, sbq[q].idx), sbq[q].val);
          sbq.delete(q);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset values
    checkVal("R1", "status", int'({upAck, upNack, upBack}), 0);
    checkVal("R1", "dnReq", int'(dnReq), 0);
    checkVal("R1", "dnHdr", int'(dnHdr), 0);
    checkVal("R1", "dnData", int'(dnData), 0);
    rstN = 1'b1;
    tick(); tick();

    // remote destination: lowest free output, accept, data, release (R2 R4 R5 R10)
    setHdr(0, 2, 3);
    upReq[0] = 1'b1;
    expectAt(2, K_DNREQ, 0, 1, "R2");
    expectAt(2, K_DNHDR, 0, 'hB, "R2");
    expectAt(2, K_DNREQ, 1, 0, "R2");
    tick(); tick();
    dnAck[0] = 1'b1;
    expectAt(1, K_ACK, 0, 1, "R4");
    tick();
    dnAck[0] = 1'b0;
    upData[7:0] = 8'hA5;
    upData[15:8] = 8'h3C;
    expectAt(1, K_DATA, 0, 'hA5, "R5");
    expectAt(1, K_DATA, 1, 0, "R5");
    expectAt(1, K_DNREQ, 0, 0, "R4");
    tick();
    upReq[0] = 1'b0;
    expectAt(1, K_ACK, 0, 0, "R10");
    expectAt(1, K_DATA, 0, 'hA5, "R10");
    expectAt(2, K_DATA, 0, 0, "R10");
    repeat (4) tick();

    // local destination whose link is busy: backtrack (R3 R9)
    setHdr(1, 1, 2);
    dnLinkFree = 4'b1011;
    upReq[1] = 1'b1;
    expectAt(2, K_BACK, 1, 1, "R3");
    expectAt(2, K_BHDR, 1, 'h6, "R3");
    expectAt(3, K_BACK, 1, 0, "R3");
    expectAt(2, K_DNREQ, 2, 0, "R9");
    tick(); tick();
    upReq[1] = 1'b0;
    tick(); tick();
    dnLinkFree = '1;
    tick();

    // single candidate rejected: nACK (R6 R7)
    setHdr(2, 1, 1);
    upReq[2] = 1'b1;
    expectAt(2, K_DNREQ, 1, 1, "R6");
    tick(); tick();
    dnNack[1] = 1'b1;
    expectAt(2, K_NACK, 2, 1, "R7");
    expectAt(2, K_DNREQ, 1, 0, "R7");
    expectAt(3, K_NACK, 2, 0, "R7");
    tick();
    dnNack[1] = 1'b0;
    tick();
    upReq[2] = 1'b0;
    tick(); tick();

    // remote probe rejected on out0 moves to out1 (R6), then accepted (R4 R5)
    setHdr(3, 3, 0);
    upReq[3] = 1'b1;
    expectAt(2, K_DNREQ, 0, 1, "R2");
    tick(); tick();
    dnNack[0] = 1'b1;
    expectAt(2, K_DNREQ, 1, 1, "R6");
    expectAt(2, K_DNREQ, 0, 0, "R6");
    expectAt(2, K_DNHDR, 1, 'hC, "R6");
    tick();
    dnNack[0] = 1'b0;
    tick();
    dnAck[1] = 1'b1;
    expectAt(1, K_ACK, 3, 1, "R4");
    tick();
    dnAck[1] = 1'b0;
    upData[31:24] = 8'h5A;
    expectAt(1, K_DATA, 1, 'h5A, "R5");
    tick();
    upReq[3] = 1'b0;
    repeat (4) tick();

    // two inputs contend for out3: round robin over two rounds (R8)
    setHdr(0, 1, 3);
    setHdr(1, 1, 3);
    upData[7:0] = 8'h11;
    upData[15:8] = 8'h22;
    upReq[0] = 1'b1;
    upReq[1] = 1'b1;
    expectAt(2, K_DNREQ, 3, 1, "R8");
    expectAt(2, K_BACK, 1, 1, "R8");
    expectAt(2, K_BACK, 0, 0, "R8");
    tick(); tick();
    dnAck[3] = 1'b1;
    upReq[1] = 1'b0;
    expectAt(1, K_ACK, 0, 1, "R8");
    tick();
    dnAck[3] = 1'b0;
    expectAt(1, K_DATA, 3, 'h11, "R8");
    tick();
    upReq[0] = 1'b0;
    tick(); tick();
    upReq[0] = 1'b1;
    upReq[1] = 1'b1;
    expectAt(2, K_BACK, 0, 1, "R8");
    expectAt(2, K_BACK, 1, 0, "R8");
    tick(); tick();
    dnAck[3] = 1'b1;
    upReq[0] = 1'b0;
    expectAt(1, K_ACK, 1, 1, "R8");
    tick();
    dnAck[3] = 1'b0;
    expectAt(1, K_DATA, 3, 'h22, "R8");
    tick();
    upReq[1] = 1'b0;
    repeat (4) tick();

    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", sbq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule